// File: doc/BRIEF.md
# Per-CPU Interrupt Claim and Retire Port

This block sits between a shared interrupt distributor and one processor. The distributor offers its current best candidate, an interrupt ID with an 8-bit priority where a smaller value is more urgent. The port decides whether that candidate may interrupt the processor and drives a single request line when it may. The processor talks to the port over a small register bus. Reads and writes have separate address inputs, so a read and a write can happen in the same cycle.

Reading the claim register takes the candidate and records it as active. The read returns the candidate's ID and sends an acknowledge pulse with that ID back to the distributor. When nothing can be taken, the read returns the reserved ID 1023 and changes nothing. Each claimed interrupt's priority goes onto a small stack. The top of that stack is the running priority, and only a strictly more urgent candidate can preempt it. Writing the retire register with the ID of the most recent claim removes that claim from the stack. The previous running priority then comes back, and equal or less urgent work can be signalled again.

A priority mask register sets a global threshold. A control register bit gates all signalling.

Top module: `irq_cpu_port`

## Requirements
- R1: After reset, the request line is low and the control register reads 0. The mask register reads 0x00, which blocks every priority. A claim read returns 1023, and the active stack is empty.
- R2: Bit 0 of the control register enables the port. While it is 0, the request line stays low and a claim read returns 1023 with no acknowledge pulse.
- R3: A candidate is signalled only when its priority is numerically less than the 8-bit mask. A priority equal to the mask is not signalled.
- R4: A candidate is signalled only when its priority is numerically less than the running priority. The running priority is that of the most recent outstanding claim, or 0xFF when nothing is active, so priority 0xFF is never signalled.
- R5: A claim read (read address 2) of a signalled candidate returns its ID in bits 9:0, with all higher bits 0. The result is on the read data one cycle after the read strobe. In that same cycle the acknowledge strobe pulses for one cycle and carries the same ID.
- R6: A claim read with no signalled candidate returns 1023, gives no acknowledge pulse and leaves the active stack unchanged.
- R7: Candidate IDs 1021, 1022 and 1023 are never signalled or claimed. ID 1020 behaves as a normal ID.
- R8: A write to the retire register (write address 3) whose bits 9:0 equal the most recent outstanding claim's ID ends that claim and restores the previous running priority. Any other ID is ignored.
- R9: At most 4 claims can be outstanding. With 4 active, no candidate is signalled and a claim read returns 1023.
- R10: The register map is: address 0 is control (bit 0 only), 1 is the mask (bits 7:0), 2 is claim (read only), 3 is retire (write only; it reads as 0). Bits that are not stored read as 0.
- R11: When a claim read and a matching retire write fall in the same cycle, the claim is qualified against the running priority from before the retire. The new claim replaces the retired stack entry, so the number of outstanding claims stays the same.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_waddr | input | 2 | Register write address |
| bus_wdata | input | 32 | Register write data |
| bus_rd | input | 1 | Register read strobe |
| bus_raddr | input | 2 | Register read address |
| bus_rdata | output | 32 | Read data, valid the cycle after the read strobe |
| cand_valid | input | 1 | Distributor has a candidate |
| cand_id | input | 10 | Candidate interrupt ID |
| cand_prio | input | 8 | Candidate priority, lower is more urgent |
| irq_out | output | 1 | Interrupt request to the processor |
| dist_ack | output | 1 | One-cycle claim acknowledge to the distributor |
| dist_ack_id | output | 10 | ID of the claimed interrupt |

## Verification
A claim read and a retire write can land on the same clock edge. The bench provokes this by holding one claim active and offering a more urgent candidate. It then raises the read strobe on the claim register and, in the same cycle, writes the retire register with the active ID. The returned ID shows that the claim was granted against the pre-retire running priority. A follow-up retire of the new ID and a probe with a mid-range candidate show whether exactly one entry was replaced: the line rises only if the stack is then empty.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    localparam int ID_W   = 10;
    localparam int PRIO_W = 8;

    // reserved "nothing to claim" ID (all ones)
    localparam logic [ID_W-1:0] SPUR_ID = '1;
    // first ID that is never handed to the processor
    localparam logic [ID_W-1:0] FIRST_RSVD_ID = SPUR_ID - ID_W'(2);

    typedef enum logic [1:0] {
        REG_CTRL  = 2'd0,
        REG_PMASK = 2'd1,
        REG_CLAIM = 2'd2,
        REG_DONE  = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic [ID_W-1:0]   id;
        logic [PRIO_W-1:0] prio;
    } act_entry_t;

    function automatic logic id_deliverable(input logic [ID_W-1:0] id);
        return id < FIRST_RSVD_ID;
    endfunction

endpackage

// File: rtl/irqc_act_stack.sv
module irqc_act_stack
    import irqc_pkg::*;
#(
    parameter int DEPTH = 4,
    localparam int CNT_W = $clog2(DEPTH + 1),
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic             pop,
    input  act_entry_t       push_ent,
    output act_entry_t       top_ent,
    output logic             empty,
    output logic             full,
    output logic [CNT_W-1:0] level
);

    logic [CNT_W-1:0] cnt_q;
    act_entry_t       slot [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else begin
            case ({push, pop})
                2'b10:   cnt_q <= cnt_q + CNT_W'(1);
                2'b01:   cnt_q <= cnt_q - CNT_W'(1);
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    // push alone writes the free slot; push with pop overwrites the top
    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        logic load_here;
        assign load_here = push &&
            ((!pop && cnt_q == CNT_W'(g)) || (pop && cnt_q == CNT_W'(g + 1)));
        always_ff @(posedge clk) begin
            if (rst)
                slot[g] <= '0;
            else if (load_here)
                slot[g] <= push_ent;
        end
    end

    logic [IDX_W-1:0] top_idx;
    assign top_idx = IDX_W'(cnt_q - CNT_W'(1));
    assign empty   = (cnt_q == '0);
    assign full    = (cnt_q == CNT_W'(DEPTH));
    assign top_ent = empty ? '0 : slot[top_idx];
    assign level   = cnt_q;

endmodule

// File: rtl/irqc_qualify.sv
module irqc_qualify
    import irqc_pkg::*;
(
    input  logic              enable,
    input  logic              cand_valid,
    input  logic [ID_W-1:0]   cand_id,
    input  logic [PRIO_W-1:0] cand_prio,
    input  logic [PRIO_W-1:0] pmask,
    input  logic [PRIO_W-1:0] run_prio,
    input  logic              stack_full,
    output logic              take_ok
);

    always_comb begin
        take_ok = enable
               && cand_valid
               && id_deliverable(cand_id)
               && (cand_prio < pmask)
               && (cand_prio < run_prio)
               && !stack_full;
    end

endmodule

// File: rtl/irq_cpu_port.sv
module irq_cpu_port
    import irqc_pkg::*;
#(
    parameter int DEPTH  = 4,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [1:0]        bus_waddr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_rd,
    input  logic [1:0]        bus_raddr,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              cand_valid,
    input  logic [ID_W-1:0]   cand_id,
    input  logic [PRIO_W-1:0] cand_prio,
    output logic              irq_out,
    output logic              dist_ack,
    output logic [ID_W-1:0]   dist_ack_id
);

    localparam int CNT_W = $clog2(DEPTH + 1);

    logic              en_q;
    logic [PRIO_W-1:0] pmask_q;
    logic [DATA_W-1:0] rdata_q;
    logic              ack_q;
    logic [ID_W-1:0]   ack_id_q;

    act_entry_t        top_ent;
    act_entry_t        new_ent;
    logic              stk_empty, stk_full;
    logic [CNT_W-1:0]  act_level;
    logic [PRIO_W-1:0] run_prio;
    logic              take_ok;
    logic              claim_rd, done_wr, claim, retire;

    logic unused_wbits;
    assign unused_wbits = ^bus_wdata[DATA_W-1:ID_W];

    assign run_prio = stk_empty ? '1 : top_ent.prio;

    irqc_qualify u_qual (
        .enable     (en_q),
        .cand_valid (cand_valid),
        .cand_id    (cand_id),
        .cand_prio  (cand_prio),
        .pmask      (pmask_q),
        .run_prio   (run_prio),
        .stack_full (stk_full),
        .take_ok    (take_ok)
    );

    assign claim_rd = bus_rd && (bus_raddr == REG_CLAIM);
    assign done_wr  = bus_wr && (bus_waddr == REG_DONE);
    assign claim    = claim_rd && take_ok;
    assign retire   = done_wr && !stk_empty && (bus_wdata[ID_W-1:0] == top_ent.id);

    assign new_ent.id   = cand_id;
    assign new_ent.prio = cand_prio;

    irqc_act_stack #(.DEPTH(DEPTH)) u_stack (
        .clk      (clk),
        .rst      (rst),
        .push     (claim),
        .pop      (retire),
        .push_ent (new_ent),
        .top_ent  (top_ent),
        .empty    (stk_empty),
        .full     (stk_full),
        .level    (act_level)
    );

    // configuration registers
    always_ff @(posedge clk) begin
        if (rst) begin
            en_q    <= 1'b0;
            pmask_q <= '0;
        end else if (bus_wr) begin
            if (bus_waddr == REG_CTRL)
                en_q <= bus_wdata[0];
            if (bus_waddr == REG_PMASK)
                pmask_q <= bus_wdata[PRIO_W-1:0];
        end
    end

    // registered read path and distributor acknowledge
    always_ff @(posedge clk) begin
        if (rst) begin
            rdata_q  <= '0;
            ack_q    <= 1'b0;
            ack_id_q <= '0;
        end else begin
            ack_q <= claim;
            if (claim)
                ack_id_q <= cand_id;
            if (bus_rd) begin
                case (bus_raddr)
                    REG_CTRL:  rdata_q <= DATA_W'(en_q);
                    REG_PMASK: rdata_q <= DATA_W'(pmask_q);
                    REG_CLAIM: rdata_q <= DATA_W'(claim ? cand_id : SPUR_ID);
                    default:   rdata_q <= '0;
                endcase
            end
        end
    end

    assign irq_out     = take_ok;
    assign bus_rdata   = rdata_q;
    assign dist_ack    = ack_q;
    assign dist_ack_id = ack_id_q;

endmodule

// File: rtl/irqc_checker.sv
module irqc_checker
    import irqc_pkg::*;
#(
    parameter int DEPTH  = 4,
    parameter int DATA_W = 32,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input logic              clk,
    input logic              rst,
    input logic              en,
    input logic [PRIO_W-1:0] pmask,
    input logic              irq,
    input logic [ID_W-1:0]   cand_id,
    input logic [PRIO_W-1:0] cand_prio,
    input logic              ack,
    input logic [ID_W-1:0]   ack_id,
    input logic [DATA_W-1:0] rdata,
    input logic              rd,
    input logic [1:0]        raddr,
    input logic [CNT_W-1:0]  level
);

    a_r2_irq_needs_enable: assert property (@(posedge clk) disable iff (rst)
        irq |-> en);

    a_r3_irq_under_mask: assert property (@(posedge clk) disable iff (rst)
        irq |-> (cand_prio < pmask));

    a_r7_no_reserved_irq: assert property (@(posedge clk) disable iff (rst)
        irq |-> (cand_id < FIRST_RSVD_ID));

    a_r5_ack_follows_read: assert property (@(posedge clk) disable iff (rst)
        ack |-> $past(rd && raddr == REG_CLAIM));

    a_r5_ack_matches_data: assert property (@(posedge clk) disable iff (rst)
        ack |-> (rdata[ID_W-1:0] == ack_id));

    a_r6_spurious_silent: assert property (@(posedge clk) disable iff (rst)
        ($past(rd && raddr == REG_CLAIM) && rdata[ID_W-1:0] == SPUR_ID) |-> !ack);

    a_r9_level_bound: assert property (@(posedge clk) disable iff (rst)
        level <= CNT_W'(DEPTH));

endmodule

bind irq_cpu_port irqc_checker #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_irqc_chk (
    .clk       (clk),
    .rst       (rst),
    .en        (en_q),
    .pmask     (pmask_q),
    .irq       (irq_out),
    .cand_id   (cand_id),
    .cand_prio (cand_prio),
    .ack       (dist_ack),
    .ack_id    (dist_ack_id),
    .rdata     (bus_rdata),
    .rd        (bus_rd),
    .raddr     (bus_raddr),
    .level     (act_level)
);

// File: tb/test_irq_cpu_port.sv
`timescale 1ns/1ps
module test_irq_cpu_port;

    logic        clk = 1'b0;
    logic        rst;
    logic        bus_wr;
    logic [1:0]  bus_waddr;
    logic [31:0] bus_wdata;
    logic        bus_rd;
    logic [1:0]  bus_raddr;
    logic [31:0] bus_rdata;
    logic        cand_valid;
    logic [9:0]  cand_id;
    logic [7:0]  cand_prio;
    logic        irq_out;
    logic        dist_ack;
    logic [9:0]  dist_ack_id;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    irq_cpu_port i_irq_cpu_port (
        .clk(clk), .rst(rst),
        .bus_wr(bus_wr), .bus_waddr(bus_waddr), .bus_wdata(bus_wdata),
        .bus_rd(bus_rd), .bus_raddr(bus_raddr), .bus_rdata(bus_rdata),
        .cand_valid(cand_valid), .cand_id(cand_id), .cand_prio(cand_prio),
        .irq_out(irq_out), .dist_ack(dist_ack), .dist_ack_id(dist_ack_id)
    );

    typedef struct packed {
        logic [7:0] mask;
        logic       valid;
        logic [9:0] id;
        logic [7:0] prio;
        logic       exp_irq;
    } vec_t;

    localparam int NVEC = 11;
    localparam vec_t VEC [NVEC] = '{
        '{8'hF0, 1'b1, 10'd32,   8'hA0, 1'b1},  // R3 below mask
        '{8'hA0, 1'b1, 10'd32,   8'hA0, 1'b0},  // R3 equal to mask
        '{8'hA1, 1'b1, 10'd32,   8'hA0, 1'b1},  // R3 one below mask
        '{8'h00, 1'b1, 10'd32,   8'h00, 1'b0},  // R3 mask zero blocks all
        '{8'hFF, 1'b1, 10'd33,   8'hFE, 1'b1},  // R4 under idle level
        '{8'hFF, 1'b1, 10'd34,   8'hFF, 1'b0},  // R4 0xFF never signalled
        '{8'hF0, 1'b0, 10'd35,   8'h10, 1'b0},  // no candidate
        '{8'hF0, 1'b1, 10'd1020, 8'h10, 1'b1},  // R7 1020 is normal
        '{8'hF0, 1'b1, 10'd1021, 8'h10, 1'b0},  // R7 reserved
        '{8'hF0, 1'b1, 10'd1022, 8'h10, 1'b0},  // R7 reserved
        '{8'hF0, 1'b1, 10'd1023, 8'h10, 1'b0}   // R7 reserved
    };

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_waddr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d,
                      output logic ack, output logic [9:0] ack_id);
        @(negedge clk);
        bus_rd = 1'b1; bus_raddr = a;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata; ack = dist_ack; ack_id = dist_ack_id;
    endtask

    task automatic cand(input logic v, input logic [9:0] id, input logic [7:0] p);
        @(negedge clk);
        cand_valid = v; cand_id = id; cand_prio = p;
        #1;
    endtask

    initial begin
        #(20 * 20000);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        logic        a;
        logic [9:0]  aid;

        rst = 1'b1;
        bus_wr = 0; bus_waddr = 0; bus_wdata = 0;
        bus_rd = 0; bus_raddr = 0;
        cand_valid = 1'b1; cand_id = 10'd40; cand_prio = 8'h10;
        repeat (3) @(negedge clk);
        check("R1 irq in reset", 32'(irq_out), 0);
        rst = 1'b0;

        // R1 reset state
        rd(2'd0, d, a, aid); check("R1 ctrl", d, 0);
        rd(2'd1, d, a, aid); check("R1 mask", d, 0);
        rd(2'd2, d, a, aid); check("R1 claim spurious", d, 1023);
        check("R1 no ack", 32'(a), 0);

        // R2 enable gating
        wr(2'd1, 32'hF0);
        cand(1'b1, 10'd40, 8'h10);
        check("R2 irq low while disabled", 32'(irq_out), 0);
        rd(2'd2, d, a, aid); check("R2 claim while disabled", d, 1023);
        check("R2 no ack while disabled", 32'(a), 0);
        wr(2'd0, 32'h1);
        #1 check("R2 irq after enable", 32'(irq_out), 1);

        // R3 R4 R7 vector table
        for (int i = 0; i < NVEC; i++) begin
            wr(2'd1, 32'(VEC[i].mask));
            cand(VEC[i].valid, VEC[i].id, VEC[i].prio);
            check($sformatf("R3/R4/R7 vector %0d", i), 32'(irq_out), 32'(VEC[i].exp_irq));
        end

        // R5 claim
        wr(2'd1, 32'hF0);
        cand(1'b1, 10'd40, 8'h40);
        rd(2'd2, d, a, aid);
        check("R5 claim data", d, 40);
        check("R5 ack pulse", 32'(a), 1);
        check("R5 ack id", 32'(aid), 40);
        #1 @(negedge clk);
        check("R5 ack one cycle", 32'(dist_ack), 0);
        // R4 running priority
        #1 check("R4 same prio blocked", 32'(irq_out), 0);
        cand(1'b1, 10'd42, 8'h3F);
        check("R4 preempt more urgent", 32'(irq_out), 1);

        // R8 retire
        cand(1'b1, 10'd43, 8'h50);
        wr(2'd3, 32'd41);
        #1 check("R8 wrong id ignored", 32'(irq_out), 0);
        wr(2'd3, 32'd40);
        #1 check("R8 matching id retires", 32'(irq_out), 1);

        // R6 spurious read changes nothing
        cand(1'b0, 10'd43, 8'h50);
        rd(2'd2, d, a, aid);
        check("R6 spurious id", d, 1023);
        check("R6 no ack", 32'(a), 0);
        cand(1'b1, 10'd43, 8'hE0);
        check("R6 stack still empty", 32'(irq_out), 1);

        // R9 depth limit
        for (int k = 0; k < 4; k++) begin
            cand(1'b1, 10'(60 + k), 8'(8'h40 - 8'(k * 16)));
            rd(2'd2, d, a, aid);
            check($sformatf("R9 nested claim %0d", k), d, 32'(60 + k));
        end
        cand(1'b1, 10'd64, 8'h05);
        check("R9 full blocks irq", 32'(irq_out), 0);
        rd(2'd2, d, a, aid);
        check("R9 full claim spurious", d, 1023);
        wr(2'd3, 32'd63);
        #1 check("R9 room after retire", 32'(irq_out), 1);
        wr(2'd3, 32'd62); wr(2'd3, 32'd61); wr(2'd3, 32'd60);
        cand(1'b1, 10'd65, 8'hE0);
        check("R8 all retired", 32'(irq_out), 1);

        // R11 claim and retire in the same cycle
        cand(1'b1, 10'd70, 8'h40);
        rd(2'd2, d, a, aid);
        check("R11 first claim", d, 70);
        cand(1'b1, 10'd71, 8'h20);
        @(negedge clk);
        bus_rd = 1'b1; bus_raddr = 2'd2;
        bus_wr = 1'b1; bus_waddr = 2'd3; bus_wdata = 32'd70;
        @(negedge clk);
        bus_rd = 1'b0; bus_wr = 1'b0;
        check("R11 same-cycle claim id", bus_rdata, 71);
        wr(2'd3, 32'd71);
        cand(1'b1, 10'd72, 8'h50);
        check("R11 stack empty after replace", 32'(irq_out), 1);

        // R10 register map
        wr(2'd0, 32'hFFFF_FFFF);
        rd(2'd0, d, a, aid); check("R10 ctrl bit0 only", d, 1);
        wr(2'd1, 32'h0000_1234);
        rd(2'd1, d, a, aid); check("R10 mask 8 bits", d, 32'h34);
        rd(2'd3, d, a, aid); check("R10 retire reads zero", d, 0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule